// File: doc/BRIEF.md
# Training-Based CFO Estimator

This block measures the carrier frequency offset of an OFDM burst from two identical time-domain training symbols that arrive ahead of the payload. A carrier offset makes the phase of the received samples advance linearly with time. Samples spaced a fixed distance apart therefore differ by a phase that is proportional to the offset. The block correlates each incoming complex sample against a delayed copy of the training stream and accumulates the products. It then converts each accumulated correlation into an angle with a shared iterative CORDIC vectoring unit.

Two correlations are formed. The first is across the two halves of the first training symbol, at a lag of half a symbol. It gives a coarse angle that stays unambiguous for offsets up to one full turn per symbol. The second is across the two training symbols, at a lag of a full symbol. It gives a precise angle that wraps at half that range. The wrap is undone by choosing the turn count that lands the precise angle nearest to twice the coarse angle. The unwrapped value is then reported as a signed phase increment per sample, together with a one-cycle done pulse. The estimate is ready a fixed, short time after the last training sample, well before a downstream rotator needs it for the payload.

Top module: `cfo_train_est`

## Requirements
- R1: After reset, estDone is 0 and estInc is 0.
- R2: For offsets of magnitude below 2^(PHASE_W-1) output units (under half a turn per symbol), estInc is within ±24 of round(f·2^(PHASE_W+log2 SYM_LEN)), where f is the offset in cycles per sample. A sample phase that advances with time gives a positive value.
- R3: For offsets of magnitude from 2^(PHASE_W-1) up to below 2^PHASE_W units, which lie beyond the range of the full-symbol correlation alone, estInc meets the same ±24 tolerance through coarse-guided unwrapping.
- R4: Cycles with sampleValid low are neither stored nor counted. A training stream with idle cycles between samples, carrying arbitrary data during those cycles, yields the same estimate as a gap-free one.
- R5: estDone is a single-cycle pulse that occurs exactly once per completed training pair. It never occurs before the cycle after the final (2·SYM_LEN-th) training sample is accepted, and it occurs at most 2·CORDIC_ITER+12 cycles after that sample.
- R6: estInc changes only in the cycle where estDone is high. It holds while payload samples stream in and while a later training pair is collected.
- R7: trainStart marks the current cycle's sample as training sample index 0. It discards any partly collected training and clears both correlations, so an aborted pair produces no pulse and the next estimate reflects only the new pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sampleValid | input | 1 | Sample on sampleI/sampleQ is valid this cycle |
| trainStart | input | 1 | This cycle's sample is the first training sample |
| sampleI | input | SAMPLE_W | In-phase sample, signed |
| sampleQ | input | SAMPLE_W | Quadrature sample, signed |
| estDone | output | 1 | One-cycle pulse when a new estimate is posted |
| estInc | output | PHASE_W+2 | Signed phase increment per sample, in units of 2^-(PHASE_W+log2 SYM_LEN) turn |

## Verification
The assertions assume that trainStart only comes with a valid first training sample, and that reset is applied from time zero. They also assume the sample counter moves only on accepted samples, so idle cycles must leave it alone. The stimulus meets these assumptions: it raises trainStart only with sampleValid high and holds reset from the first cycle. During gaps it drives random data with sampleValid low. It keeps every offset within the coarse range, and its training symbols repeat exactly at the half-symbol period apart from the applied rotation.

// File: rtl/cfo_train_pkg.sv
package cfo_train_pkg;

  // Strobes issued by the control unit to the datapath each cycle
  typedef struct packed {
    logic clearAcc;     // zero both correlators
    logic writeSample;  // store current sample in the symbol buffer
    logic accCoarse;    // add half-lag product
    logic accFine;      // add full-lag product
    logic cordStart;    // launch CORDIC on selected correlator
    logic cordSelFine;  // select full-lag correlator for CORDIC
    logic latchCoarse;  // capture CORDIC angle as coarse angle
    logic latchFine;    // capture CORDIC angle as fine angle
    logic publish;      // combine angles and post the estimate
  } ctlStrb_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_COLLECT, ST_CSTART, ST_CWAIT, ST_FSTART, ST_FWAIT, ST_PUBLISH
  } ctlState_t;

  // atan(2^-idx) as a fraction of a full turn, scaled by 2^32
  function automatic logic [31:0] atanTurn32(input int idx);
    case (idx)
      0:  atanTurn32 = 32'd536870912;
      1:  atanTurn32 = 32'd316933406;
      2:  atanTurn32 = 32'd167458907;
      3:  atanTurn32 = 32'd85004756;
      4:  atanTurn32 = 32'd42667331;
      5:  atanTurn32 = 32'd21354465;
      6:  atanTurn32 = 32'd10679838;
      7:  atanTurn32 = 32'd5340245;
      8:  atanTurn32 = 32'd2670163;
      9:  atanTurn32 = 32'd1335087;
      10: atanTurn32 = 32'd667544;
      11: atanTurn32 = 32'd333772;
      12: atanTurn32 = 32'd166886;
      13: atanTurn32 = 32'd83443;
      14: atanTurn32 = 32'd41722;
      15: atanTurn32 = 32'd20861;
      default: atanTurn32 = 32'd0;
    endcase
  endfunction

endpackage

// File: rtl/cfo_train_cordic.sv
module cfo_train_cordic #(
  parameter int IN_W    = 36,
  parameter int PHASE_W = 16,
  parameter int ITER    = 14,
  localparam int CW     = IN_W + 2,
  localparam int IW     = $clog2(ITER)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic signed [IN_W-1:0]    inX,
  input  logic signed [IN_W-1:0]    inY,
  output logic                      busy,
  output logic                      done,
  output logic [PHASE_W-1:0]        angle
);
  localparam logic [IW-1:0]      LAST_IT   = IW'(ITER - 1);
  localparam logic [PHASE_W-1:0] HALF_TURN = {1'b1, {(PHASE_W-1){1'b0}}};

  logic [PHASE_W-1:0] atanLut [ITER];

  for (genvar g = 0; g < ITER; g++) begin : g_lut
    localparam logic [31:0] RAW = cfo_train_pkg::atanTurn32(g);
    localparam logic [31:0] RND = (RAW + (32'd1 << (31 - PHASE_W))) >> (32 - PHASE_W);
    assign atanLut[g] = RND[PHASE_W-1:0];
  end

  logic signed [CW-1:0] xR, yR, xExt, yExt, shX, shY;
  logic [PHASE_W-1:0]   zR;
  logic [IW-1:0]        iterR;
  logic                 busyR, doneR;

  assign xExt = {{2{inX[IN_W-1]}}, inX};
  assign yExt = {{2{inY[IN_W-1]}}, inY};
  assign shX  = xR >>> iterR;
  assign shY  = yR >>> iterR;

  always_ff @(posedge clk) begin
    if (rst) begin
      xR <= '0; yR <= '0; zR <= '0; iterR <= '0;
      busyR <= 1'b0; doneR <= 1'b0;
    end else begin
      doneR <= 1'b0;
      if (start) begin
        // fold left half-plane onto the right by a half-turn rotation
        if (inX[IN_W-1]) begin
          xR <= -xExt; yR <= -yExt; zR <= HALF_TURN;
        end else begin
          xR <= xExt;  yR <= yExt;  zR <= '0;
        end
        iterR <= '0;
        busyR <= 1'b1;
      end else if (busyR) begin
        if (!yR[CW-1]) begin
          xR <= xR + shY; yR <= yR - shX; zR <= zR + atanLut[iterR];
        end else begin
          xR <= xR - shY; yR <= yR + shX; zR <= zR - atanLut[iterR];
        end
        iterR <= iterR + 1'b1;
        if (iterR == LAST_IT) begin
          busyR <= 1'b0;
          doneR <= 1'b1;
        end
      end
    end
  end

  assign busy  = busyR;
  assign done  = doneR;
  assign angle = zR;
endmodule

// File: rtl/cfo_train_ctl.sv
module cfo_train_ctl import cfo_train_pkg::*; #(
  parameter int SYM_LEN = 2048,
  localparam int LOGN   = $clog2(SYM_LEN),
  localparam int CNT_W  = LOGN + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sampleValid,
  input  logic             trainStart,
  input  logic             cordDone,
  output ctlStrb_t         strb,
  output logic [LOGN-1:0]  wrAddr,
  output logic [CNT_W-1:0] sampCnt
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(2 * SYM_LEN - 1);

  ctlState_t        state;
  logic [CNT_W-1:0] cnt, kIdx;
  logic             accept;

  always_comb begin
    kIdx   = trainStart ? '0 : cnt;
    accept = sampleValid && (trainStart || state == ST_COLLECT);
    strb             = '0;
    strb.clearAcc    = trainStart;
    strb.writeSample = accept;
    // half-lag window: second half of the first symbol
    strb.accCoarse   = accept && !kIdx[LOGN] && kIdx[LOGN-1];
    // full-lag window: the whole second symbol
    strb.accFine     = accept && kIdx[LOGN];
    strb.cordStart   = (state == ST_CSTART) || (state == ST_FSTART);
    strb.cordSelFine = (state == ST_FSTART);
    strb.latchCoarse = (state == ST_CWAIT) && cordDone;
    strb.latchFine   = (state == ST_FWAIT) && cordDone;
    strb.publish     = (state == ST_PUBLISH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (trainStart) begin
      state <= ST_COLLECT;
      cnt   <= sampleValid ? CNT_W'(1) : '0;
    end else begin
      case (state)
        ST_COLLECT: if (accept) begin
          cnt <= cnt + 1'b1;
          if (kIdx == LAST_IDX) state <= ST_CSTART;
        end
        ST_CSTART:  state <= ST_CWAIT;
        ST_CWAIT:   if (cordDone) state <= ST_FSTART;
        ST_FSTART:  state <= ST_FWAIT;
        ST_FWAIT:   if (cordDone) state <= ST_PUBLISH;
        ST_PUBLISH: state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  assign wrAddr  = kIdx[LOGN-1:0];
  assign sampCnt = cnt;
endmodule

// File: rtl/cfo_train_dp.sv
module cfo_train_dp import cfo_train_pkg::*; #(
  parameter int SAMPLE_W    = 12,
  parameter int SYM_LEN     = 2048,
  parameter int PHASE_W     = 16,
  parameter int CORDIC_ITER = 14,
  localparam int LOGN       = $clog2(SYM_LEN),
  localparam int PRODW      = 2 * SAMPLE_W + 1,
  localparam int AW         = PRODW + LOGN,
  localparam int EST_W      = PHASE_W + 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  ctlStrb_t                   strb,
  input  logic [LOGN-1:0]            wrAddr,
  input  logic signed [SAMPLE_W-1:0] sampI,
  input  logic signed [SAMPLE_W-1:0] sampQ,
  output logic                       cordBusy,
  output logic                       cordDone,
  output logic                       estDone,
  output logic signed [EST_W-1:0]    estInc
);
  localparam logic [LOGN-1:0] HALF = LOGN'(SYM_LEN / 2);

  logic signed [SAMPLE_W-1:0] bufI [SYM_LEN];
  logic signed [SAMPLE_W-1:0] bufQ [SYM_LEN];

  always_ff @(posedge clk) begin
    if (strb.writeSample) begin
      bufI[wrAddr] <= sampI;
      bufQ[wrAddr] <= sampQ;
    end
  end

  // Delayed sample: full lag reads the slot about to be overwritten
  logic [LOGN-1:0]            halfAddr, rdAddr;
  logic signed [SAMPLE_W-1:0] oldI, oldQ;
  assign halfAddr = wrAddr - HALF;
  assign rdAddr   = strb.accFine ? wrAddr : halfAddr;
  assign oldI     = bufI[rdAddr];
  assign oldQ     = bufQ[rdAddr];

  // current * conj(delayed)
  logic signed [PRODW-1:0] aI, aQ, bI, bQ, pRe, pIm;
  assign aI  = PRODW'(sampI);
  assign aQ  = PRODW'(sampQ);
  assign bI  = PRODW'(oldI);
  assign bQ  = PRODW'(oldQ);
  assign pRe = aI * bI + aQ * bQ;
  assign pIm = aQ * bI - aI * bQ;

  logic signed [AW-1:0] accCRe, accCIm, accFRe, accFIm;

  always_ff @(posedge clk) begin
    if (rst || strb.clearAcc) begin
      accCRe <= '0; accCIm <= '0; accFRe <= '0; accFIm <= '0;
    end else begin
      if (strb.accCoarse) begin
        accCRe <= accCRe + AW'(pRe);
        accCIm <= accCIm + AW'(pIm);
      end
      if (strb.accFine) begin
        accFRe <= accFRe + AW'(pRe);
        accFIm <= accFIm + AW'(pIm);
      end
    end
  end

  logic signed [AW-1:0] cordX, cordY;
  logic [PHASE_W-1:0]   cordAng;
  assign cordX = strb.cordSelFine ? accFRe : accCRe;
  assign cordY = strb.cordSelFine ? accFIm : accCIm;

  cfo_train_cordic #(.IN_W(AW), .PHASE_W(PHASE_W), .ITER(CORDIC_ITER)) cordic_i (
    .clk(clk), .rst(rst), .start(strb.cordStart), .inX(cordX), .inY(cordY),
    .busy(cordBusy), .done(cordDone), .angle(cordAng)
  );

  logic [PHASE_W-1:0] coarseAng, fineAng;

  always_ff @(posedge clk) begin
    if (rst) begin
      coarseAng <= '0;
      fineAng   <= '0;
    end else begin
      if (strb.latchCoarse) coarseAng <= cordAng;
      if (strb.latchFine)   fineAng   <= cordAng;
    end
  end

  // Unwrap: fine angle placed within half a turn of twice the coarse angle
  logic signed [EST_W-1:0]   twoC, estNext;
  logic signed [PHASE_W-1:0] wrapDiff;
  assign twoC     = {coarseAng[PHASE_W-1], coarseAng, 1'b0};
  assign wrapDiff = fineAng - twoC[PHASE_W-1:0];
  assign estNext  = twoC + {{2{wrapDiff[PHASE_W-1]}}, wrapDiff};

  always_ff @(posedge clk) begin
    if (rst) begin
      estDone <= 1'b0;
      estInc  <= '0;
    end else begin
      estDone <= strb.publish;
      if (strb.publish) estInc <= estNext;
    end
  end
endmodule

// File: rtl/cfo_train_est.sv
module cfo_train_est import cfo_train_pkg::*; #(
  parameter int SAMPLE_W    = 12,
  parameter int SYM_LEN     = 2048,
  parameter int PHASE_W     = 16,
  parameter int CORDIC_ITER = 14,
  localparam int LOGN       = $clog2(SYM_LEN),
  localparam int EST_W      = PHASE_W + 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sampleValid,
  input  logic                       trainStart,
  input  logic signed [SAMPLE_W-1:0] sampleI,
  input  logic signed [SAMPLE_W-1:0] sampleQ,
  output logic                       estDone,
  output logic signed [EST_W-1:0]    estInc
);
  ctlStrb_t        strb;
  logic [LOGN-1:0] wrAddr;
  logic [LOGN:0]   sampCnt;
  logic            cordBusy, cordDone;

  cfo_train_ctl #(.SYM_LEN(SYM_LEN)) ctl_i (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .trainStart(trainStart),
    .cordDone(cordDone), .strb(strb), .wrAddr(wrAddr), .sampCnt(sampCnt)
  );

  cfo_train_dp #(
    .SAMPLE_W(SAMPLE_W), .SYM_LEN(SYM_LEN), .PHASE_W(PHASE_W), .CORDIC_ITER(CORDIC_ITER)
  ) dp_i (
    .clk(clk), .rst(rst), .strb(strb), .wrAddr(wrAddr), .sampI(sampleI), .sampQ(sampleQ),
    .cordBusy(cordBusy), .cordDone(cordDone), .estDone(estDone), .estInc(estInc)
  );
endmodule

// File: rtl/cfo_train_chk.sv
module cfo_train_chk #(
  parameter int EST_W = 18,
  parameter int CNT_W = 12
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    sampleValid,
  input logic                    trainStart,
  input logic                    estDone,
  input logic signed [EST_W-1:0] estInc,
  input logic                    cordStart,
  input logic                    cordBusy,
  input logic [CNT_W-1:0]        sampCnt
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    estDone |=> !estDone);  // R5

  AST_CORDIC_FREE: assert property (@(posedge clk) disable iff (rst)
    cordStart |-> !cordBusy);  // R5

  AST_EST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !estDone |-> $stable(estInc));  // R6

  AST_GAP_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
    (!sampleValid && !trainStart) |=> $stable(sampCnt));  // R4

  AST_START_INDEX: assert property (@(posedge clk) disable iff (rst)
    (trainStart && sampleValid) |=> (sampCnt == CNT_W'(1)));  // R7
endmodule

bind cfo_train_est cfo_train_chk #(.EST_W(EST_W), .CNT_W(LOGN + 1)) chk_i (
  .clk(clk), .rst(rst), .sampleValid(sampleValid), .trainStart(trainStart),
  .estDone(estDone), .estInc(estInc), .cordStart(strb.cordStart),
  .cordBusy(cordBusy), .sampCnt(sampCnt)
);

// File: tb/cfo_train_est_tb_top.sv
module cfo_train_est_tb_top;
  localparam int SW    = 12;
  localparam int N     = 2048;
  localparam int L     = N / 2;
  localparam int PW    = 16;
  localparam int ITER  = 14;
  localparam int TOL   = 24;
  localparam int MAXLAT = 2 * ITER + 12;
  localparam real TWO_PI = 6.283185307179586;
  localparam real AMP    = 1500.0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sampleValid = 1'b0;
  logic trainStart = 1'b0;
  logic signed [SW-1:0] sampleI = '0;
  logic signed [SW-1:0] sampleQ = '0;
  logic estDone;
  logic signed [PW+1:0] estInc;

  int checks = 0;
  int errors = 0;
  int donePulses = 0;
  int lastEst = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cfo_train_est #(.SAMPLE_W(SW), .SYM_LEN(N), .PHASE_W(PW), .CORDIC_ITER(ITER)) dut_i (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .trainStart(trainStart),
    .sampleI(sampleI), .sampleQ(sampleQ), .estDone(estDone), .estInc(estInc)
  );

  always @(negedge clk) if (!rst && estDone) donePulses++;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic real pattern(input int m);
    return real'((m * 73 + 11) % 97) / 97.0;
  endfunction

  task automatic putSample(input int k, input int inc, input bit first);
    real ph;
    @(negedge clk);
    ph = TWO_PI * (real'(inc) * real'(k) / 134217728.0 + pattern(k % L));
    sampleValid = 1'b1;
    trainStart  = first;
    sampleI     = SW'(int'(AMP * $cos(ph)));
    sampleQ     = SW'(int'(AMP * $sin(ph)));
    #1;
  endtask

  task automatic putIdle();
    @(negedge clk);
    sampleValid = 1'b0;
    trainStart  = 1'b0;
    sampleI     = SW'(int'($urandom % 4096) - 2048);
    sampleQ     = SW'(int'($urandom % 4096) - 2048);
    #1;
  endtask

  task automatic putPayload();
    @(negedge clk);
    sampleValid = 1'b1;
    trainStart  = 1'b0;
    sampleI     = SW'(int'($urandom % 4096) - 2048);
    sampleQ     = SW'(int'($urandom % 4096) - 2048);
    #1;
  endtask

  // Full burst: training pair, then payload; checks accuracy, timing, hold
  task automatic runBurst(input int inc, input bit gaps, input string req);
    int pulses0;
    int lat;
    int got;
    pulses0 = donePulses;
    for (int k = 0; k < 2 * N; k++) begin
      if (gaps && (k % 5 == 3)) begin
        putIdle();
        if (k % 10 == 3) putIdle();
      end
      putSample(k, inc, k == 0);
    end
    check(donePulses == pulses0, "R5", "no done before last training sample",
          donePulses - pulses0, 0);
    lat = 0;
    while (donePulses == pulses0 && lat < 200) begin
      putPayload();
      lat++;
    end
    check(lat >= 1 && lat <= MAXLAT, "R5", "done latency after last sample", lat, MAXLAT);
    got = int'(estInc);
    check(got - inc <= TOL && inc - got <= TOL, req, $sformatf("estimate for offset %0d", inc),
          got, inc);
    for (int p = 0; p < 300; p++) putPayload();
    check(donePulses == pulses0 + 1, "R5", "single done pulse per burst",
          donePulses - pulses0, 1);
    check(int'(estInc) == got, "R6", "estimate held during payload", int'(estInc), got);
    lastEst = got;
  endtask

  task automatic testReset();
    @(negedge clk);
    #1;
    check(estDone == 1'b0, "R1", "estDone after reset", int'(estDone), 0);
    check(int'(estInc) == 0, "R1", "estInc after reset", int'(estInc), 0);
  endtask

  task automatic testFineRange();
    runBurst(0, 1'b0, "R2");
    runBurst(10000, 1'b0, "R2");
    runBurst(-25000, 1'b0, "R2");
  endtask

  task automatic testWideRange();
    runBurst(50000, 1'b0, "R3");
    runBurst(-60000, 1'b0, "R3");
  endtask

  task automatic testGaps();
    runBurst(-20000, 1'b1, "R4");
  endtask

  task automatic testRestart();
    int pulses0;
    int held;
    pulses0 = donePulses;
    held = lastEst;
    for (int k = 0; k < 1500; k++) putSample(k, 30000, k == 0);
    for (int k = 0; k < 100; k++) putIdle();
    check(donePulses == pulses0, "R7", "aborted training gives no pulse",
          donePulses - pulses0, 0);
    check(int'(estInc) == held, "R6", "estimate held across new training",
          int'(estInc), held);
    runBurst(-45000, 1'b0, "R7");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    testReset();
    testFineRange();
    testWideRange();
    testGaps();
    testRestart();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 190000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule